// File: doc/BRIEF.md
# Address-Sequence Store Command Detector

This block sits beside a parallel, asynchronous-style SRAM bus that has been brought into a clock domain. It samples the bus on every clock edge and looks for a fixed series of six read addresses which, taken together, ask for the SRAM contents to be copied to nonvolatile storage. When the series completes it emits a one-cycle store request. It then holds the memory unavailable for a programmable number of clock cycles, which covers the time the copy takes.

A separate active-low hardware store-request pin also shapes the bus. A write that is already under way when the pin falls is allowed to complete. Any write that begins after that is refused until the pin is released. Reads are never disturbed by the sequence tracking: sequence reads return ordinary data. Only the busy window removes the memory from the bus.

One bus cycle is one clock edge at which chip enable is sampled low. The cycle is a read when write enable is high and a write when write enable is low.

Top module: `nv_store_seq_detect`

## Requirements
- R1: Six read cycles at addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, raise `store_pulse` for exactly one cycle, in the cycle after the edge that sampled the last read. A read is `ce_n`=0 with `we_n`=1.
- R2: The level of `oe_n` has no effect on whether a read counts toward the sequence.
- R3: A read at an address other than the one expected next returns the tracker to idle. If that address is 0x0E38, the read counts as step one of a new sequence.
- R4: A write cycle (`ce_n`=0, `we_n`=0) returns the tracker to idle.
- R5: Cycles with `ce_n`=1 placed between sequence reads neither advance nor reset the tracker.
- R6: `busy` and `oe_inhibit` rise together with `store_pulse` and stay high for exactly STORE_CYCLES cycles. While `busy` is high, `mem_rd_ok`, `mem_wr_ok` and `dq_drive` are 0, and bus cycles do not advance the tracker, which is idle when `busy` falls.
- R7: While `hsb_n`=0, `wr_inhibit` is 1 from the cycle after an edge that saw `hsb_n` low with no write in progress, and `mem_wr_ok` is 0 for any write.
- R8: A write in progress when `hsb_n` falls keeps `mem_wr_ok`=1 until it ends. `wr_inhibit` rises in the cycle after that write ends.
- R9: `wr_inhibit` returns to 0 in the cycle after an edge that sampled `hsb_n`=1.
- R10: Outside the busy window, `mem_rd_ok` equals the combinational read condition and `dq_drive` equals read with `oe_n`=0. This holds during sequence tracking and while `wr_inhibit` is set.
- R11: During reset, `store_pulse`, `busy`, `oe_inhibit` and `wr_inhibit` are 0, and the tracker is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Bus address |
| hsb_n | input | 1 | Hardware store request, active low |
| store_pulse | output | 1 | One-cycle nonvolatile store request |
| busy | output | 1 | Store window in progress; memory unavailable |
| oe_inhibit | output | 1 | Data outputs forced to high impedance |
| wr_inhibit | output | 1 | Writes refused because of the hardware request |
| mem_rd_ok | output | 1 | Current read may reach the array |
| mem_wr_ok | output | 1 | Current write may reach the array |
| dq_drive | output | 1 | Data pins may be driven this cycle |

## Verification
The bench builds the block with STORE_CYCLES set to 20. This keeps the whole busy window inside a short run, so the bench can count its length cycle by cycle. It can also feed five sequence reads into that window and then confirm, once the window closes, that the final address fires nothing. The address width is fixed at 15 bits, so every sequence address and every near-miss address is driven exactly as specified.

// File: rtl/nv_store_seq_detect.sv
module nv_store_seq_detect #(
  parameter int STORE_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [14:0] addr,
  input  logic        hsb_n,
  output logic        store_pulse,
  output logic        busy,
  output logic        oe_inhibit,
  output logic        wr_inhibit,
  output logic        mem_rd_ok,
  output logic        mem_wr_ok,
  output logic        dq_drive
);
  localparam int CNT_W   = $clog2(STORE_CYCLES + 1);
  localparam int STEPS   = 6;
  localparam int STEP_W  = $clog2(STEPS);

  function automatic logic [14:0] seq_addr(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    seq_addr = 15'h0E38;
      3'd1:    seq_addr = 15'h31C7;
      3'd2:    seq_addr = 15'h03E0;
      3'd3:    seq_addr = 15'h3C1F;
      3'd4:    seq_addr = 15'h303F;
      default: seq_addr = 15'h0FC0;
    endcase
  endfunction

  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cnt;
  logic              pulse_q;
  logic              inh_q;

  wire rd_acc = !ce_n &&  we_n;
  wire wr_acc = !ce_n && !we_n;
  wire hit    = (addr == seq_addr(step));
  wire last   = (step == STEP_W'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      cnt     <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (cnt != '0) begin
        cnt  <= cnt - 1'b1;
        step <= '0;
      end else if (rd_acc) begin
        if (hit && last) begin
          step    <= '0;
          pulse_q <= 1'b1;
          cnt     <= CNT_W'(STORE_CYCLES);
        end else if (hit) begin
          step <= step + 1'b1;
        end else begin
          step <= (addr == seq_addr('0)) ? STEP_W'(1) : '0;
        end
      end else if (wr_acc) begin
        step <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      inh_q <= 1'b0;
    else if (hsb_n)  inh_q <= 1'b0;
    else if (!wr_acc) inh_q <= 1'b1;
  end

  assign store_pulse = pulse_q;
  assign busy        = (cnt != '0);
  assign oe_inhibit  = busy;
  assign wr_inhibit  = inh_q;
  assign mem_rd_ok   = rd_acc && !busy;
  assign mem_wr_ok   = wr_acc && !busy && !inh_q;
  assign dq_drive    = rd_acc && !oe_n && !oe_inhibit;

  logic [CNT_W:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_pulse_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |-> ($past(rd_acc) && $past(addr) == 15'h0FC0));

  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> !store_pulse);

  p_pulse_opens_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |-> (busy && !$past(busy)));

  p_window_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (CNT_W+1)'(STORE_CYCLES)));

  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!mem_rd_ok && !mem_wr_ok && !dq_drive));

  p_inhibit_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && !hsb_n) |=> wr_inhibit);

  p_write_finishes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hsb_n) && $past(wr_acc) && wr_acc) |=> !wr_inhibit);

  p_inhibit_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hsb_n |=> !wr_inhibit);
endmodule

// File: tb/test_nv_store_seq_detect.sv
module test_nv_store_seq_detect;
  localparam int NCYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hsb_n = 1'b1;
  logic [14:0] addr = '0;
  logic store_pulse, busy, oe_inhibit, wr_inhibit, mem_rd_ok, mem_wr_ok, dq_drive;
  logic rd_c, wr_c, dq_c;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  nv_store_seq_detect #(.STORE_CYCLES(NCYC)) i_nv_store_seq_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .hsb_n(hsb_n), .store_pulse(store_pulse), .busy(busy),
    .oe_inhibit(oe_inhibit), .wr_inhibit(wr_inhibit), .mem_rd_ok(mem_rd_ok),
    .mem_wr_ok(mem_wr_ok), .dq_drive(dq_drive));

  // {ce_n, we_n, oe_n, expected store_pulse after the edge, addr}
  localparam logic [18:0] VEC [16] = '{
    {4'b0100, 15'h0E38}, {4'b0110, 15'h31C7}, {4'b0100, 15'h0000},
    {4'b0100, 15'h03E0}, {4'b0100, 15'h3C1F}, {4'b0100, 15'h303F},
    {4'b0100, 15'h0FC0}, {4'b0100, 15'h0E38}, {4'b0100, 15'h31C7},
    {4'b0100, 15'h03E0}, {4'b0110, 15'h0E38}, {4'b0100, 15'h31C7},
    {4'b0110, 15'h03E0}, {4'b0100, 15'h3C1F}, {4'b0100, 15'h303F},
    {4'b0101, 15'h0FC0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic w, input logic o, input logic [14:0] a);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a;
    #1;
    rd_c = mem_rd_ok; wr_c = mem_wr_ok; dq_c = dq_drive;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [14:0] a); bus(1'b0, 1'b1, 1'b0, a); endtask
  task automatic idle(); bus(1'b1, 1'b1, 1'b1, 15'h0); endtask

  task automatic seq_head(input int n);
    logic [14:0] s [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};
    for (int k = 0; k < n; k++) rd(s[k]);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 pulse", store_pulse, 1'b0);
    chk("R11 busy", busy, 1'b0);
    chk("R11 oe_inhibit", oe_inhibit, 1'b0);
    chk("R11 wr_inhibit", wr_inhibit, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R10: vector table
    for (int i = 0; i < 16; i++) begin
      bus(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][14:0]);
      chk("R3/R1 vector pulse", store_pulse, VEC[i][15]);
      if (i < 15) begin
        chk("R10 read ok during tracking", rd_c, 1'b1);
        chk("R10 dq follows oe_n", dq_c, !VEC[i][16]);
      end
    end

    // R6: window length and blocking, sequence ignored inside window
    n = 0;
    chk("R6 oe_inhibit with pulse", oe_inhibit, 1'b1);
    while (busy && n < 100) begin
      n++;
      if (n <= 5) begin
        seq_head(1);
        chk("R6 read blocked", rd_c, 1'b0);
        chk("R6 dq blocked", dq_c, 1'b0);
      end else if (n == 6) begin
        bus(1'b0, 1'b0, 1'b1, 15'h0);
        chk("R6 write blocked", wr_c, 1'b0);
      end else idle();
    end
    chk("R6 window length", n == NCYC, 1'b1);
    chk("R6 oe_inhibit released", oe_inhibit, 1'b0);

    // R6: five sequence reads inside the window, final one after it
    seq_head(6); // fires, opens a new window
    chk("R1 repeat store", store_pulse, 1'b1);
    seq_head(5);
    n = 0;
    while (busy && n < 100) begin n++; idle(); end
    rd(15'h0FC0);
    chk("R6 tracker idle after window", store_pulse, 1'b0);

    // R4: write resets the tracker
    seq_head(3);
    bus(1'b0, 1'b0, 1'b1, 15'h3C1F);
    rd(15'h3C1F); rd(15'h303F); rd(15'h0FC0);
    chk("R4 write aborts", store_pulse, 1'b0);

    // R5: deselect between steps keeps progress
    rd(15'h0E38); idle(); idle(); rd(15'h31C7); idle();
    rd(15'h03E0); rd(15'h3C1F); idle(); rd(15'h303F); idle(); idle();
    rd(15'h0FC0);
    chk("R5 deselect keeps progress", store_pulse, 1'b1);
    n = 0;
    while (busy && n < 100) begin n++; idle(); end

    // R7: hsb low with no write
    @(negedge clk); hsb_n = 1'b0;
    idle();
    chk("R7 wr_inhibit set", wr_inhibit, 1'b1);
    bus(1'b0, 1'b0, 1'b1, 15'h0010);
    chk("R7 write refused", wr_c, 1'b0);
    rd(15'h0011);
    chk("R10 read ok under wr_inhibit", rd_c, 1'b1);

    // R9: release
    @(negedge clk); hsb_n = 1'b1;
    idle();
    chk("R9 wr_inhibit cleared", wr_inhibit, 1'b0);
    bus(1'b0, 1'b0, 1'b1, 15'h0012);
    chk("R9 write accepted", wr_c, 1'b1);

    // R8: write in progress when hsb falls
    @(negedge clk); hsb_n = 1'b0;
    bus(1'b0, 1'b0, 1'b1, 15'h0012);
    chk("R8 in-progress write ok", wr_c, 1'b1);
    chk("R8 no inhibit during write", wr_inhibit, 1'b0);
    bus(1'b0, 1'b0, 1'b1, 15'h0012);
    chk("R8 write still ok", wr_c, 1'b1);
    idle();
    chk("R8 inhibit after write ends", wr_inhibit, 1'b1);
    bus(1'b0, 1'b0, 1'b1, 15'h0013);
    chk("R8 later write refused", wr_c, 1'b0);
    @(negedge clk); hsb_n = 1'b1;
    idle();

    // R11: reset mid-sequence leaves tracker idle
    seq_head(4);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R11 busy in reset", busy, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    rd(15'h303F); rd(15'h0FC0);
    chk("R11 tracker cleared", store_pulse, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule